// File: doc/BRIEF.md
# Byte Extract, Insert and Mask Unit

This block carries out the byte-granular data manipulations that a 64-bit integer datapath uses to build sub-quadword loads and stores out of whole-quadword accesses and to pack or unpack byte fields. It takes operand A, operand B (a register value or a literal), a function code and a field size. For the positional functions, the low three bits of B give a byte offset. For the zeroing functions, the low eight bits of B act as a per-byte select. For the packed compare, B is a second vector of eight bytes.

The functions are:
- extract, in low and high forms;
- insert, in low and high forms;
- mask, in low and high forms;
- zero selected bytes (zap) and keep selected bytes (zapnot);
- an eight-way unsigned byte compare.

The positional functions work on fields of one, two, four or eight bytes. A low form handles the part of a field that lies at byte positions 0 to 7 after the shift. The matching high form handles the part that spills past byte 7.

The function logic itself is combinational. Its result is captured in one output register, loaded when the clock enable is high, so a result appears one clock after it is issued. The register clears asynchronously on reset, and the reset is released in step with the clock.

Top module: `byteop_unit`

## Requirements
- R1: While reset is held, the result reads 0. Once reset has been released, the result register loads the function output on a clock edge where `en` is 1 and holds its value on a clock edge where `en` is 0.
- R2: Function code 0 (compare) sets result bit i when byte i of A is greater than or equal to byte i of B, comparing them as unsigned values. Result bits 63:8 are 0.
- R3: Function code 1 (extract low) shifts A right by B[2:0] bytes and keeps the low 1, 2, 4 or 8 bytes, for size code 0, 1, 2 or 3. All other bytes are 0.
- R4: Function code 2 (extract high) shifts A left by (8 − B[2:0]) mod 8 bytes and keeps the low bytes given by the size code. When B[2:0] is 0, the result is 0.
- R5: Function code 3 (insert low) places the low bytes of A, of the sized field, at byte offset B[2:0]. Only the field bytes that land at positions 0 to 7 appear, and all other bytes are 0.
- R6: Function code 4 (insert high) outputs the field bytes that would land above byte 7 when the field is inserted at offset B[2:0]. These bytes appear at positions 0 upward, and all other bytes are 0. When B[2:0] is 0, the result is 0.
- R7: Function code 5 (mask low) clears the bytes of A covered by the sized field placed at offset B[2:0] within positions 0 to 7, and passes every other byte of A through.
- R8: Function code 6 (mask high) clears the bytes of A at positions 0 upward that the sized field at offset B[2:0] covers past byte 7, and passes every other byte of A through.
- R9: Function code 7 (zap) clears byte i of A when B[i] is 1. Function code 8 (zapnot) clears byte i of A when B[i] is 0.
- R10: The positional functions use only B[2:0], and zap and zapnot use only B[7:0]. The other bits of B have no effect on the result.
- R11: Function codes 9 to 15 produce a result of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Load enable for the result register |
| fn | input | 4 | Function code |
| sz | input | 2 | Field size code: 0 byte, 1 two bytes, 2 four bytes, 3 eight bytes |
| a | input | 64 | Operand A |
| b | input | 64 | Operand B (offset, byte select or compare operand) |
| result | output | 64 | Registered result |

## Verification
The positional functions are driven with a single operand A whose eight bytes are all different, so every result byte shows which source byte reached it and where. Offsets include 0, the middle values and 7. Field sizes are combined with offsets so that some fields fit entirely below byte 7 and others split across it, which separates the low forms from the high forms. The compare is tried with equal bytes, with bytes that differ by one in either direction and with bytes whose top bit differs, which exposes a signed compare. B carries set upper bits to show that those bits are ignored, and undefined function codes and the register hold are checked directly.

// File: rtl/byteop_pkg.sv
`timescale 1ns/1ps
package byteop_pkg;

  typedef enum logic [3:0] {
    FN_CMPGE  = 4'd0,
    FN_EXTL   = 4'd1,
    FN_EXTH   = 4'd2,
    FN_INSL   = 4'd3,
    FN_INSH   = 4'd4,
    FN_MSKL   = 4'd5,
    FN_MSKH   = 4'd6,
    FN_ZAP    = 4'd7,
    FN_ZAPNOT = 4'd8
  } bop_fn_e;

  typedef enum logic [1:0] {
    SZ_B1 = 2'd0,
    SZ_B2 = 2'd1,
    SZ_B4 = 2'd2,
    SZ_B8 = 2'd3
  } bop_sz_e;

  localparam int unsigned FN_LAST = 8;

endpackage

// File: rtl/bop_byte_shift.sv
`timescale 1ns/1ps
// Byte-granular barrel shifter: each output byte selects one input byte
// by the shift amount, zero when the source lies outside the word.
module bop_byte_shift #(
  parameter int unsigned NBYTES = 8,
  parameter int unsigned BYTE_W = 8,
  parameter bit          LEFT   = 1'b0,
  localparam int unsigned DW    = NBYTES * BYTE_W,
  localparam int unsigned OFFW  = $clog2(NBYTES)
) (
  input  logic [DW-1:0]   din,
  input  logic [OFFW-1:0] amt,
  output logic [DW-1:0]   dout
);

  logic [BYTE_W-1:0] cand [NBYTES][NBYTES];

  for (genvar j = 0; j < NBYTES; j++) begin : g_out
    for (genvar k = 0; k < NBYTES; k++) begin : g_amt
      localparam int SRC = LEFT ? (j - k) : (j + k);
      if (SRC >= 0 && SRC < NBYTES) begin : g_in
        assign cand[j][k] = din[SRC*BYTE_W +: BYTE_W];
      end else begin : g_zero
        assign cand[j][k] = '0;
      end
    end
    assign dout[j*BYTE_W +: BYTE_W] = cand[j][amt];
  end

endmodule

// File: rtl/bop_field_mask.sv
`timescale 1ns/1ps
// Builds the per-byte field select and its low and high parts after
// placement at a byte offset.
module bop_field_mask
  import byteop_pkg::*;
#(
  parameter int unsigned NBYTES = 8,
  localparam int unsigned OFFW  = $clog2(NBYTES)
) (
  input  bop_sz_e           sz,
  input  logic [OFFW-1:0]   off,
  output logic [NBYTES-1:0] field,
  output logic [NBYTES-1:0] lo,
  output logic [NBYTES-1:0] hi
);

  logic [2*NBYTES-1:0] placed;

  always_comb begin
    for (int i = 0; i < NBYTES; i++) begin
      field[i] = (32'(i) < (32'd1 << sz));
    end
  end

  assign placed = {{NBYTES{1'b0}}, field} << off;
  assign lo     = placed[NBYTES-1:0];
  assign hi     = placed[2*NBYTES-1:NBYTES];

endmodule

// File: rtl/bop_byte_cmp.sv
`timescale 1ns/1ps
// Packed unsigned greater-or-equal compare, one bit per byte lane.
module bop_byte_cmp #(
  parameter int unsigned NBYTES = 8,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned DW    = NBYTES * BYTE_W
) (
  input  logic [DW-1:0]     a,
  input  logic [DW-1:0]     b,
  output logic [NBYTES-1:0] ge
);

  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    assign ge[i] = a[i*BYTE_W +: BYTE_W] >= b[i*BYTE_W +: BYTE_W];
  end

endmodule

// File: rtl/byteop_unit.sv
`timescale 1ns/1ps
module byteop_unit
  import byteop_pkg::*;
#(
  parameter int unsigned NBYTES = 8,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned DW    = NBYTES * BYTE_W,
  localparam int unsigned OFFW  = $clog2(NBYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [3:0]    fn,
  input  logic [1:0]    sz,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] result
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // Offsets for the low and high forms.
  logic [OFFW-1:0] off_lo;
  logic [OFFW-1:0] off_hi;
  logic            off_zero;

  assign off_lo   = b[OFFW-1:0];
  assign off_hi   = OFFW'(NBYTES - 32'(off_lo));
  assign off_zero = (off_lo == '0);

  // Shifter network.
  logic [DW-1:0] sh_r_lo, sh_l_hi, sh_l_lo, sh_r_hi;

  bop_byte_shift #(.NBYTES(NBYTES), .BYTE_W(BYTE_W), .LEFT(1'b0)) u_sh_extl (
    .din(a), .amt(off_lo), .dout(sh_r_lo));
  bop_byte_shift #(.NBYTES(NBYTES), .BYTE_W(BYTE_W), .LEFT(1'b1)) u_sh_exth (
    .din(a), .amt(off_hi), .dout(sh_l_hi));
  bop_byte_shift #(.NBYTES(NBYTES), .BYTE_W(BYTE_W), .LEFT(1'b1)) u_sh_insl (
    .din(a), .amt(off_lo), .dout(sh_l_lo));
  bop_byte_shift #(.NBYTES(NBYTES), .BYTE_W(BYTE_W), .LEFT(1'b0)) u_sh_insh (
    .din(a), .amt(off_hi), .dout(sh_r_hi));

  // Field masks.
  logic [NBYTES-1:0] fld_m, lo_m, hi_m;

  bop_field_mask #(.NBYTES(NBYTES)) u_mask (
    .sz(bop_sz_e'(sz)), .off(off_lo), .field(fld_m), .lo(lo_m), .hi(hi_m));

  // Packed compare.
  logic [NBYTES-1:0] ge_v;

  bop_byte_cmp #(.NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_cmp (
    .a(a), .b(b), .ge(ge_v));

  function automatic logic [DW-1:0] widen(input logic [NBYTES-1:0] m);
    logic [DW-1:0] w;
    for (int i = 0; i < NBYTES; i++) begin
      w[i*BYTE_W +: BYTE_W] = {BYTE_W{m[i]}};
    end
    return w;
  endfunction

  // Next-state selection.
  logic [DW-1:0] result_d;
  logic [DW-1:0] result_q;

  always_comb begin
    result_d = '0;
    case (fn)
      FN_CMPGE:  result_d = {{(DW-NBYTES){1'b0}}, ge_v};
      FN_EXTL:   result_d = sh_r_lo & widen(fld_m);
      FN_EXTH:   result_d = off_zero ? '0 : (sh_l_hi & widen(fld_m));
      FN_INSL:   result_d = sh_l_lo & widen(lo_m);
      FN_INSH:   result_d = off_zero ? '0 : (sh_r_hi & widen(hi_m));
      FN_MSKL:   result_d = a & ~widen(lo_m);
      FN_MSKH:   result_d = a & ~widen(hi_m);
      FN_ZAP:    result_d = a & ~widen(b[NBYTES-1:0]);
      FN_ZAPNOT: result_d = a & widen(b[NBYTES-1:0]);
      default:   result_d = '0;
    endcase
  end

  // Result register with clock enable.
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  result_q <= '0;
    else if (en)      result_q <= result_d;
  end

  assign result = result_q;

endmodule

// File: rtl/byteop_chk.sv
`timescale 1ns/1ps
module byteop_chk #(
  parameter int unsigned NBYTES = 8,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned DW    = NBYTES * BYTE_W,
  localparam int unsigned OFFW  = $clog2(NBYTES)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic [3:0]    fn,
  input logic [1:0]    sz,
  input logic [DW-1:0] a,
  input logic [DW-1:0] b,
  input logic [DW-1:0] result
);

  // R1
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(result));

  // R2
  cmp_upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && fn == 4'd0) |=> (result[DW-1:NBYTES] == '0));

  // R3
  extl_byte_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && fn == 4'd1 && sz == 2'd0) |=> (result[DW-1:BYTE_W] == '0));

  // R4
  exth_zero_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && fn == 4'd2 && b[OFFW-1:0] == '0) |=> (result == '0));

  // R6
  insh_zero_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && fn == 4'd4 && b[OFFW-1:0] == '0) |=> (result == '0));

  // R7
  mask_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (fn == 4'd5 || fn == 4'd6)) |=> ((result & ~$past(a)) == '0));

  // R9
  zap_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (fn == 4'd7 || fn == 4'd8)) |=> ((result & ~$past(a)) == '0));

  // R11
  undef_fn_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && fn > 4'd8) |=> (result == '0));

endmodule

bind byteop_unit byteop_chk #(.NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .en(en), .fn(fn), .sz(sz),
  .a(a), .b(b), .result(result));

// File: tb/sim_byteop_unit.sv
`timescale 1ns/1ps
module sim_byteop_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        en;
  logic [3:0]  fn;
  logic [1:0]  sz;
  logic [63:0] a, b;
  logic [63:0] result;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  byteop_unit u0 (.clk(clk), .rst_n(rst_n), .en(en), .fn(fn), .sz(sz),
                  .a(a), .b(b), .result(result));

  typedef struct packed {
    logic [3:0]  f;
    logic [1:0]  s;
    logic [63:0] va;
    logic [63:0] vb;
    logic [63:0] ex;
    logic [7:0]  rq;
  } vec_t;

  localparam logic [63:0] PA = 64'h0123_4567_89AB_CDEF;
  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{4'd1, 2'd0, PA, 64'h3, 64'h89, 8'd3},                                   // R3
    '{4'd1, 2'd1, PA, 64'h6, 64'h0123, 8'd3},                                 // R3
    '{4'd1, 2'd2, PA, 64'h5, 64'h0001_2345, 8'd3},                            // R3
    '{4'd1, 2'd3, PA, 64'h0, PA, 8'd3},                                       // R3
    '{4'd2, 2'd3, PA, 64'h3, 64'hABCD_EF00_0000_0000, 8'd4},                  // R4
    '{4'd2, 2'd1, PA, 64'h7, 64'hEF00, 8'd4},                                 // R4
    '{4'd2, 2'd3, PA, 64'h0, 64'h0, 8'd4},                                    // R4
    '{4'd3, 2'd1, PA, 64'h3, 64'h0000_00CD_EF00_0000, 8'd5},                  // R5
    '{4'd3, 2'd2, PA, 64'h6, 64'hCDEF_0000_0000_0000, 8'd5},                  // R5
    '{4'd4, 2'd2, PA, 64'h6, 64'h89AB, 8'd6},                                 // R6
    '{4'd4, 2'd3, PA, 64'h0, 64'h0, 8'd6},                                    // R6
    '{4'd4, 2'd0, PA, 64'h7, 64'h0, 8'd6},                                    // R6
    '{4'd5, 2'd1, PA, 64'h7, 64'h0023_4567_89AB_CDEF, 8'd7},                  // R7
    '{4'd5, 2'd2, PA, 64'h2, 64'h0123_0000_0000_CDEF, 8'd7},                  // R7
    '{4'd6, 2'd3, PA, 64'h3, 64'h0123_4567_8900_0000, 8'd8},                  // R8
    '{4'd6, 2'd2, PA, 64'h0, PA, 8'd8},                                       // R8
    '{4'd7, 2'd0, PA, 64'h0F, 64'h0123_4567_0000_0000, 8'd9},                 // R9
    '{4'd8, 2'd0, PA, 64'h81, 64'h0100_0000_0000_00EF, 8'd9},                 // R9
    '{4'd0, 2'd0, PA, PA, 64'hFF, 8'd2},                                      // R2
    '{4'd0, 2'd0, 64'h00FF_7F80_0102_0304, 64'h01FE_8080_0103_0203,
      64'h5B, 8'd2},                                                          // R2
    '{4'd1, 2'd0, PA, 64'hFFFF_FFFF_FFFF_FF03, 64'h89, 8'd10},                // R10
    '{4'd7, 2'd0, PA, 64'hFFFF_FFFF_FFFF_FF00, PA, 8'd10}                     // R10
  };

  task automatic check(input string tag, input logic [63:0] got,
                       input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic issue(input logic [3:0] f, input logic [1:0] s,
                       input logic [63:0] va, input logic [63:0] vb);
    @(negedge clk);
    fn = f; sz = s; a = va; b = vb; en = 1'b1;
    @(negedge clk);
    en = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b0; fn = '0; sz = '0; a = '0; b = '0;
    repeat (4) @(negedge clk);
    check("R1 reset value", result, 64'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after release", result, 64'h0);

    for (int i = 0; i < NV; i++) begin
      issue(VECS[i].f, VECS[i].s, VECS[i].va, VECS[i].vb);
      check($sformatf("R%0d vector %0d", VECS[i].rq, i), result, VECS[i].ex);
    end

    // R11: undefined codes give zero
    issue(4'd12, 2'd3, PA, 64'h3);
    check("R11 code 12", result, 64'h0);
    issue(4'd9, 2'd0, PA, 64'hFF);
    check("R11 code 9", result, 64'h0);

    // R1: hold while en is low
    issue(4'd8, 2'd0, PA, 64'h0F);
    fn = 4'd1; a = 64'hFFFF_FFFF_FFFF_FFFF; b = 64'h0;
    repeat (2) @(negedge clk);
    check("R1 hold with en low", result, 64'h0000_0000_89AB_CDEF);

    // R2: signed-looking top bit, unsigned compare
    issue(4'd0, 2'd0, 64'h80, 64'h7F);
    check("R2 top bit unsigned", result, 64'hFF);

    // R1: asynchronous clear in mid-run
    #1 rst_n = 1'b0;
    #1 check("R1 async clear", result, 64'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule